// File: doc/BRIEF.md
# Serial Control Register Port

This block receives 16-bit write-only command words on a three-wire serial link made of a bit clock, a data line and a latch strobe. It decodes each word into an address and a data field and stores the data in one of nine registers. Six registers hold a 10-bit volume level, one per audio channel. Three hold control settings. Every setting is presented on its own parallel output, so the audio datapath can use it without any further decoding.

The serial pins are synchronised into the system clock domain and oversampled there, so the whole port runs on one clock. The sender shifts a word in MSB first and then pulses the latch. A word is committed only if exactly sixteen bit-clock rising edges arrived since the previous latch. The power-down setting follows a two-step rule. A write to the first control register only stages the new power-down value. The output takes the staged value at the next valid commit to an implemented register, so the host sends the command twice.

Top module: `ctl_serial_port`

## Requirements
- R1: A word is 16 bits, shifted in MSB first. Data is sampled on each rising edge of `ser_clk`. Bits 15..12 are the address, bits 11..10 are ignored and bits 9..0 are the data. A rising edge of `ser_latch` commits the word.
- R2: If a rising edge of `ser_latch` follows any number of `ser_clk` rising edges other than exactly 16 (for example 15 or 17), the word is discarded and no output or staged value changes.
- R3: Addresses 0 to 5 write the volume registers in the channel order L1, R1, L2, R2, L3, R3. Channel i appears on `vol_all[10*i+9:10*i]`.
- R4: Address 8 sets four fields at once: `deemph_sel` from data bits 9..8, `fmt_sel` from bits 7..5, `wlen_sel` from bits 4..3 and `interp_sel` from bits 1..0.
- R5: Data bit 2 of an address-8 write goes into a staged power-down value. `pwr_down` takes the staged value at the next valid commit to an implemented address (0..5, 8, 9, 10). The same commit that stages a new value also moves the previously staged value to `pwr_down`.
- R6: Address 9 sets `mute[5:0]` from data bits 5..0. Bit i mutes channel i, 1 means muted and 0 means unmuted.
- R7: Address 10 sets `replicate` from data bit 5.
- R8: Writes to addresses 6, 7 and 11..15 are ignored. They change no output and do not move the staged power-down value.
- R9: While `rst_n` is low, every volume reads 1023. All control fields, `mute`, `replicate`, `pwr_down` and the staged power-down value read 0.
- R10: A committed write appears on the outputs at the third rising edge of `clk` after `ser_latch` rises. The outputs do not change at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial pins are oversampled with it |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock |
| ser_dat | input | 1 | Serial data, valid at the rising edge of `ser_clk` |
| ser_latch | input | 1 | Latch strobe; its rising edge commits the word |
| vol_all | output | 60 | Six 10-bit volume levels, channel i at bits 10*i+9..10*i |
| mute | output | 6 | Per-channel mute, 1 = muted |
| deemph_sel | output | 2 | De-emphasis curve select |
| fmt_sel | output | 3 | Serial audio format select |
| wlen_sel | output | 2 | Audio word length select |
| interp_sel | output | 2 | Interpolation ratio select |
| pwr_down | output | 1 | Power-down, updated one valid commit late |
| replicate | output | 1 | Copy channel pair 1 to pairs 2 and 3 |

## Verification
Every result of this block is due at one point: the third `clk` rising edge after `ser_latch` goes high. The path is two synchroniser flops followed by the register bank. The bench changes the pins only on falling clock edges. For each frame it samples at the falling edge after the second rising edge, where it expects the old values, and again after the third, where it expects the new ones. This way every frame checks both the latency and the hold. The two-write power-down rule is covered by giving the staged value its own bench variable, which moves to the expected `pwr_down` only on frames that are valid and implemented.

// File: rtl/ctl_port_pkg.sv
package ctl_port_pkg;
  localparam int FRAME_W = 16;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 10;

  localparam logic [ADDR_W-1:0] ADDR_CTL1 = 4'd8;
  localparam logic [ADDR_W-1:0] ADDR_CTL2 = 4'd9;
  localparam logic [ADDR_W-1:0] ADDR_CTL3 = 4'd10;

  localparam int PD_BIT  = 2;
  localparam int REP_BIT = 5;

  typedef struct packed {
    logic [1:0] deemph;
    logic [2:0] fmt;
    logic [1:0] wlen;
    logic       pd;
    logic [1:0] interp;
  } ctl1_t;

  function automatic logic [ADDR_W-1:0] frame_addr(input logic [FRAME_W-1:0] f);
    return f[FRAME_W-1 -: ADDR_W];
  endfunction

  function automatic logic [DATA_W-1:0] frame_data(input logic [FRAME_W-1:0] f);
    return f[DATA_W-1:0];
  endfunction

  function automatic logic addr_is_vol(input logic [ADDR_W-1:0] a, input int nch);
    return int'(a) < nch;
  endfunction

  function automatic logic addr_implemented(input logic [ADDR_W-1:0] a, input int nch);
    return addr_is_vol(a, nch) || a == ADDR_CTL1 || a == ADDR_CTL2 || a == ADDR_CTL3;
  endfunction
endpackage

// File: rtl/ctl_pin_sync.sv
module ctl_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic rise
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], pin};
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/ctl_frame_rx.sv
module ctl_frame_rx #(
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_rise,
  input  logic          bit_val,
  input  logic          latch_rise,
  output logic          frame_ok,
  output logic          frame_bad,
  output logic [FW-1:0] frame
);
  localparam int CW  = $clog2(FW + 2);
  localparam int SAT = FW + 1;

  logic [CW-1:0] bit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame   <= '0;
      bit_cnt <= '0;
    end else if (latch_rise) begin
      bit_cnt <= '0;
    end else if (bit_rise) begin
      frame <= {frame[FW-2:0], bit_val};
      if (bit_cnt != CW'(SAT)) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign frame_ok  = latch_rise && (bit_cnt == CW'(FW));
  assign frame_bad = latch_rise && (bit_cnt != CW'(FW));
endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
  import ctl_port_pkg::*;
#(
  parameter int NUM_CH = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     commit,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        data,
  output logic [NUM_CH*DATA_W-1:0] vol_all,
  output logic [NUM_CH-1:0]        mute,
  output ctl1_t                    ctl1,
  output logic                     pd_pend,
  output logic                     replicate
);
  localparam logic [DATA_W-1:0] VOL_FULL = '1;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_vol
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 vol_all[g*DATA_W +: DATA_W] <= VOL_FULL;
      else if (commit && addr == ADDR_W'(g))      vol_all[g*DATA_W +: DATA_W] <= data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl1      <= '0;
      pd_pend   <= 1'b0;
      mute      <= '0;
      replicate <= 1'b0;
    end else if (commit && addr_implemented(addr, NUM_CH)) begin
      ctl1.pd <= pd_pend;
      if (addr == ADDR_CTL1) begin
        ctl1.deemph <= data[9:8];
        ctl1.fmt    <= data[7:5];
        ctl1.wlen   <= data[4:3];
        ctl1.interp <= data[1:0];
        pd_pend     <= data[PD_BIT];
      end
      if (addr == ADDR_CTL2) mute      <= data[NUM_CH-1:0];
      if (addr == ADDR_CTL3) replicate <= data[REP_BIT];
    end
  end
endmodule

// File: rtl/ctl_serial_port.sv
module ctl_serial_port
  import ctl_port_pkg::*;
#(
  parameter int NUM_CH      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ser_clk,
  input  logic                     ser_dat,
  input  logic                     ser_latch,
  output logic [NUM_CH*DATA_W-1:0] vol_all,
  output logic [NUM_CH-1:0]        mute,
  output logic [1:0]               deemph_sel,
  output logic [2:0]               fmt_sel,
  output logic [1:0]               wlen_sel,
  output logic [1:0]               interp_sel,
  output logic                     pwr_down,
  output logic                     replicate
);
  logic clk_rise, unused_clk_lvl;
  logic dat_lvl, unused_dat_rise;
  logic lat_rise, unused_lat_lvl;
  logic frame_ok, frame_bad;
  logic [FRAME_W-1:0] frame;
  logic [ADDR_W-1:0]  commit_addr;
  logic [DATA_W-1:0]  commit_data;
  logic               pd_pend;
  ctl1_t              ctl1;
  logic               unused_rsv;

  ctl_pin_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
    .clk(clk), .rst_n(rst_n), .pin(ser_clk), .level(unused_clk_lvl), .rise(clk_rise));
  ctl_pin_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
    .clk(clk), .rst_n(rst_n), .pin(ser_dat), .level(dat_lvl), .rise(unused_dat_rise));
  ctl_pin_sync #(.STAGES(SYNC_STAGES)) u_sync_lat (
    .clk(clk), .rst_n(rst_n), .pin(ser_latch), .level(unused_lat_lvl), .rise(lat_rise));

  ctl_frame_rx #(.FW(FRAME_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .bit_rise(clk_rise), .bit_val(dat_lvl),
    .latch_rise(lat_rise), .frame_ok(frame_ok), .frame_bad(frame_bad), .frame(frame));

  assign commit_addr = frame_addr(frame);
  assign commit_data = frame_data(frame);
  assign unused_rsv  = ^frame[FRAME_W-ADDR_W-1:DATA_W];

  ctl_reg_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk(clk), .rst_n(rst_n), .commit(frame_ok), .addr(commit_addr), .data(commit_data),
    .vol_all(vol_all), .mute(mute), .ctl1(ctl1), .pd_pend(pd_pend), .replicate(replicate));

  assign deemph_sel = ctl1.deemph;
  assign fmt_sel    = ctl1.fmt;
  assign wlen_sel   = ctl1.wlen;
  assign interp_sel = ctl1.interp;
  assign pwr_down   = ctl1.pd;
endmodule

// File: rtl/ctl_serial_port_chk.sv
module ctl_serial_port_chk
  import ctl_port_pkg::*;
#(
  parameter int NUM_CH = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     frame_ok,
  input logic                     frame_bad,
  input logic [ADDR_W-1:0]        commit_addr,
  input logic [DATA_W-1:0]        commit_data,
  input logic                     pd_pend,
  input logic [NUM_CH*DATA_W-1:0] vol_all,
  input logic [NUM_CH-1:0]        mute,
  input logic [1:0]               deemph_sel,
  input logic [2:0]               fmt_sel,
  input logic [1:0]               wlen_sel,
  input logic [1:0]               interp_sel,
  input logic                     pwr_down,
  input logic                     replicate
);
  logic [NUM_CH+10:0] ctl_bus;
  assign ctl_bus = {deemph_sel, fmt_sel, wlen_sel, interp_sel, pwr_down, mute, replicate};

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_ok |=> $stable(vol_all) && $stable(ctl_bus) && $stable(pd_pend));

  p_discard_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_bad |=> $stable(vol_all) && $stable(ctl_bus) && $stable(pd_pend));

  p_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok && !addr_implemented(commit_addr, NUM_CH)
      |=> $stable(vol_all) && $stable(ctl_bus) && $stable(pd_pend));

  p_pd_late_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok && addr_implemented(commit_addr, NUM_CH) |=> pwr_down == $past(pd_pend));

  p_pd_stage_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok && commit_addr == ADDR_CTL1 |=> pd_pend == $past(commit_data[PD_BIT]));

  p_ctl1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok && commit_addr == ADDR_CTL1
      |=> {deemph_sel, fmt_sel, wlen_sel, interp_sel} == $past({commit_data[9:3], commit_data[1:0]}));

  p_mute_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok && commit_addr == ADDR_CTL2 |=> mute == $past(commit_data[NUM_CH-1:0]));

  p_rep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok && commit_addr == ADDR_CTL3 |=> replicate == $past(commit_data[REP_BIT]));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_vchk
    p_vol_r3: assert property (@(posedge clk) disable iff (!rst_n)
      frame_ok && commit_addr == ADDR_W'(g) |=> vol_all[g*DATA_W +: DATA_W] == $past(commit_data));
  end
endmodule

bind ctl_serial_port ctl_serial_port_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok), .frame_bad(frame_bad),
  .commit_addr(commit_addr), .commit_data(commit_data), .pd_pend(pd_pend),
  .vol_all(vol_all), .mute(mute), .deemph_sel(deemph_sel), .fmt_sel(fmt_sel),
  .wlen_sel(wlen_sel), .interp_sel(interp_sel), .pwr_down(pwr_down), .replicate(replicate));

// File: tb/tb_ctl_serial_port.sv
`timescale 1ns/1ps
module tb_ctl_serial_port;
  localparam int NCH  = 6;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_latch = 1'b0;
  logic [NCH*10-1:0] vol_all;
  logic [NCH-1:0] mute;
  logic [1:0] deemph_sel, wlen_sel, interp_sel;
  logic [2:0] fmt_sel;
  logic pwr_down, replicate;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [9:0] e_vol [NCH];
  logic [5:0] e_mute;
  logic [1:0] e_deemph, e_wlen, e_interp;
  logic [2:0] e_fmt;
  logic e_pd, e_pend, e_rep;

  always #2.5 clk = ~clk;

  ctl_serial_port dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_latch(ser_latch),
    .vol_all(vol_all), .mute(mute), .deemph_sel(deemph_sel), .fmt_sel(fmt_sel),
    .wlen_sel(wlen_sel), .interp_sel(interp_sel), .pwr_down(pwr_down), .replicate(replicate));

  task automatic check_eq(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < NCH; i++) check_eq(tag, $sformatf("vol%0d", i), 32'(vol_all[i*10 +: 10]), 32'(e_vol[i]));
    check_eq(tag, "mute", 32'(mute), 32'(e_mute));
    check_eq(tag, "deemph", 32'(deemph_sel), 32'(e_deemph));
    check_eq(tag, "fmt", 32'(fmt_sel), 32'(e_fmt));
    check_eq(tag, "wlen", 32'(wlen_sel), 32'(e_wlen));
    check_eq(tag, "interp", 32'(interp_sel), 32'(e_interp));
    check_eq(tag, "pwr_down", 32'(pwr_down), 32'(e_pd));
    check_eq(tag, "replicate", 32'(replicate), 32'(e_rep));
  endtask

  // Expected effect of a valid 16-bit word, from the requirements
  task automatic model(input logic [3:0] a, input logic [9:0] d);
    logic impl;
    impl = (a < 4'(NCH)) || a == 4'd8 || a == 4'd9 || a == 4'd10;
    if (impl) e_pd = e_pend;
    if (a < 4'(NCH)) e_vol[a] = d;
    if (a == 4'd8) begin
      e_deemph = d[9:8]; e_fmt = d[7:5]; e_wlen = d[4:3]; e_interp = d[1:0]; e_pend = d[2];
    end
    if (a == 4'd9) e_mute = d[5:0];
    if (a == 4'd10) e_rep = d[5];
  endtask

  // Shift n bits (MSB of the n first), latch, check old values after 2 edges, new after 3 (R10)
  task automatic send(input logic [31:0] w, input int n, input string tag);
    for (int b = n - 1; b >= 0; b--) begin
      ser_dat = w[b];
      ser_clk = 1'b0;
      repeat (HALF) @(negedge clk);
      ser_clk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    ser_clk = 1'b0;
    repeat (3) @(negedge clk);
    ser_latch = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check_all("R10 hold");
    if (n == 16) model(w[15:12], w[9:0]);
    @(posedge clk); @(negedge clk);
    check_all(tag);
    ser_latch = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] word(input logic [3:0] a, input logic [9:0] d, input logic [1:0] rsv);
    return {16'b0, a, rsv, d};
  endfunction

  initial begin
    for (int i = 0; i < NCH; i++) e_vol[i] = 10'h3FF;
    e_mute = '0; e_deemph = '0; e_fmt = '0; e_wlen = '0; e_interp = '0;
    e_pd = 1'b0; e_pend = 1'b0; e_rep = 1'b0;
    repeat (4) @(negedge clk);
    check_all("R9 reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R9 after release");

    // R1 R3: per-channel volume patterns, reserved bits set to confirm they are ignored
    for (int c = 0; c < NCH; c++) begin
      send(word(4'(c), 10'h2AA, 2'b11), 16, "R1 R3 volume");
      send(word(4'(c), 10'h155, 2'b00), 16, "R1 R3 volume");
      send(word(4'(c), 10'(c * 97 + 5), 2'b01), 16, "R3 volume");
    end
    send(word(4'd0, 10'h000, 2'b00), 16, "R3 volume zero");
    send(word(4'd5, 10'h3FF, 2'b00), 16, "R3 volume full");

    // R4 R5: sweep every field combination of control I, power-down bit by parity
    for (int i = 0; i < 512; i++) begin
      logic [8:0] v;
      v = 9'(i);
      send(word(4'd8, {v[8:2], ^v, v[1:0]}, 2'b00), 16, "R4 R5 ctl1 sweep");
    end

    // R5: explicit two-write rule
    send(word(4'd8, 10'h004, 2'b00), 16, "R5 staged");
    send(word(4'd8, 10'h004, 2'b00), 16, "R5 second");
    check_eq("R5", "pd after two writes", 32'(pwr_down), 32'd1);
    send(word(4'd8, 10'h000, 2'b00), 16, "R5 stage clear");
    check_eq("R5", "pd still set", 32'(pwr_down), 32'd1);
    send(word(4'd2, 10'h123, 2'b00), 16, "R5 promote by volume");
    check_eq("R5", "pd cleared", 32'(pwr_down), 32'd0);

    // R6: every mute pattern, reserved bits 9..6 set
    for (int m = 0; m < 64; m++) send(word(4'd9, {4'hF, 6'(m)}, 2'b00), 16, "R6 mute");

    // R7
    send(word(4'd10, 10'h3FF, 2'b00), 16, "R7 replicate on");
    send(word(4'd10, 10'h3DF, 2'b00), 16, "R7 replicate off");
    send(word(4'd10, 10'h020, 2'b00), 16, "R7 replicate on");

    // R8: stage pd=1, then reserved writes must not move it nor change anything
    send(word(4'd8, 10'h004, 2'b00), 16, "R8 stage");
    for (int a = 0; a < 16; a++)
      if (a == 6 || a == 7 || a > 10) send(word(4'(a), 10'h3FF - 10'(a), 2'b00), 16, "R8 reserved");
    check_eq("R8", "pd unmoved", 32'(pwr_down), 32'd0);
    send(word(4'd9, 10'h000, 2'b00), 16, "R8 then valid");

    // R2: wrong bit counts are discarded
    send({16'b0, 4'd1, 2'b00, 10'h0F0} >> 1, 15, "R2 15 bits");
    send({15'b0, 1'b1, 4'd1, 2'b00, 10'h00F}, 17, "R2 17 bits");
    send(0, 0, "R2 zero bits");
    send(word(4'd8, 10'h3FB, 2'b00) >> 1, 15, "R2 15 bits ctl1");
    send(word(4'd1, 10'h0F0, 2'b00), 16, "R2 recover");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule